// File: doc/BRIEF.md
# Sense-Reversing Barrier Synchronizer

This block gathers N agents at a shared rendezvous point. Each agent signals arrival with a one-cycle pulse on its own `arrive_i` bit. The unit keeps one arrival counter, one global phase bit and a private sense bit for every agent.

When an arrival is accepted, the agent's sense bit is inverted and the counter is incremented. These two actions happen together as one indivisible step. The acceptance that brings the count to N clears the counter and copies the new sense value into the phase bit. Every agent whose sense now matches the phase is then released with a single pulse.

Because each episode uses the opposite sense value, the same barrier can be entered again in the very next cycle. No second clearing pass is needed, and there is no race between the end of one episode and the start of the next. Simultaneous arrivals are ordered by a fixed-priority arbiter, and that arbiter takes the place of a software lock. Arrival, release and error signals are single-cycle control pins with no handshake, because no data flows through the block.

Top module: `sbar_unit`

## Requirements
- R1: After reset, the counter, the phase output `phase_o` and every agent sense bit are 0, and `release_o` and `dup_err_o` are low.
- R2: Every accepted arrival inverts that agent's sense bit and adds one to the counter. Fewer than N distinct accepted arrivals in an episode never produce a release, and `phase_o` stays unchanged.
- R3: At most one arrival is accepted per cycle. If `arrive_i` pulses with no earlier request still pending, it is accepted at that same clock edge. Simultaneous or queued requests are accepted one per edge, lowest index first. None is lost: k simultaneous requests take k consecutive edges.
- R4: At the edge that accepts the N-th arrival, the counter returns to 0 and `phase_o` toggles to the new sense value. `phase_o` changes at no other time.
- R5: `release_o` has all N bits high for exactly one cycle. That cycle is the first cycle in which `phase_o` shows its new value. The last arriver is included.
- R6: `release_o` is never high in a cycle where `phase_o` did not just change.
- R7: An agent may arrive again in its release cycle or at any later cycle. That arrival counts toward the next episode and raises no error.
- R8: An `arrive_i` pulse from an agent that is still waiting, whether counted or pending, is ignored. It does not change the counter or the release timing. `dup_err_o` is high for the one cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive_i | input | N | One-cycle arrival pulse per agent |
| release_o | output | N | One-cycle release pulse per agent |
| phase_o | output | 1 | Global phase (flag) bit |
| dup_err_o | output | 1 | Pulse after a duplicate arrival |

## Verification
Two events can land in the same cycle, and the bench provokes both. In the first, the release pulse of one episode coincides with a fresh arrival that opens the next episode: an agent arrives in its own release cycle, and the bench expects no error and a correct count for the new episode. In the second, a duplicate arrival falls while other requests are still queued in the arbiter: four agents arrive together and one of them pulses again one cycle later. The bench expects an error pulse in the following cycle and a release exactly four edges after the group arrival. A scoreboard predicts the release cycle and phase from arrival counts alone and compares them cycle by cycle with the outputs.

// File: rtl/sbar_pkg.sv
package sbar_pkg;
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sbar_arbiter.sv
module sbar_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_prio
    assign gnt[i]     = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
endmodule

// File: rtl/sbar_sense_bank.sv
module sbar_sense_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flip,
  output logic [N-1:0] sense_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sense_q[i] <= 1'b0;
      else if (flip[i]) sense_q[i] <= ~sense_q[i];
    end
  end
endmodule

// File: rtl/sbar_episode.sv
module sbar_episode #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          new_sense,
  output logic [CW-1:0] cnt_q,
  output logic          phase_q,
  output logic          last
);
  localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

  assign last = take && (cnt_q == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (last) begin
      cnt_q   <= '0;
      phase_q <= new_sense;
    end else if (take) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sbar_unit.sv
module sbar_unit #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] arrive_i,
  output logic [N-1:0] release_o,
  output logic         phase_o,
  output logic         dup_err_o
);
  import sbar_pkg::*;
  localparam int CW = cnt_width(N);

  logic [N-1:0]  sense_q, sense_next, waiting, pend_q, fresh, dup, req, gnt, rel_d;
  logic [CW-1:0] cnt_q;
  logic          phase_q, last, new_sense;

  // an agent is waiting while its sense differs from the phase
  assign waiting = sense_q ^ {N{phase_q}};
  assign dup     = arrive_i & (waiting | pend_q);
  assign fresh   = arrive_i & ~waiting & ~pend_q;
  assign req     = pend_q | fresh;

  sbar_arbiter #(.N(N)) u_arb (
    .req (req),
    .gnt (gnt)
  );

  sbar_sense_bank #(.N(N)) u_sense (
    .clk     (clk),
    .rst_n   (rst_n),
    .flip    (gnt),
    .sense_q (sense_q)
  );

  assign sense_next = sense_q ^ gnt;
  assign new_sense  = |(gnt & ~sense_q);

  sbar_episode #(.N(N), .CW(CW)) u_epi (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (|gnt),
    .new_sense (new_sense),
    .cnt_q     (cnt_q),
    .phase_q   (phase_q),
    .last      (last)
  );

  for (genvar i = 0; i < N; i++) begin : g_rel
    assign rel_d[i] = last & (sense_next[i] == new_sense);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      release_o <= '0;
      dup_err_o <= 1'b0;
    end else begin
      pend_q    <= req & ~gnt;
      release_o <= rel_d;
      dup_err_o <= |dup;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/sbar_unit_chk.sv
module sbar_unit_chk #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  rel,
  input logic          phase,
  input logic [N-1:0]  req,
  input logic [N-1:0]  gnt,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_LIM = CW'(N);

  AST_CNT_RANGE:      assert property (@(posedge clk) disable iff (!rst_n) cnt < CNT_LIM); // R2
  AST_ONE_GRANT:      assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R3
  AST_NO_STALL:       assert property (@(posedge clk) disable iff (!rst_n) (req != '0) |-> (gnt != '0)); // R3
  AST_PHASE_WITH_REL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(phase) |-> (rel != '0)); // R4
  AST_REL_ALL:        assert property (@(posedge clk) disable iff (!rst_n) (rel != '0) |-> (rel == '1)); // R5
  AST_REL_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) (rel != '0) |=> (rel == '0)); // R5
  AST_REL_WITH_PHASE: assert property (@(posedge clk) disable iff (!rst_n) (rel != '0) |-> !$stable(phase)); // R6
endmodule

bind sbar_unit sbar_unit_chk #(.N(N), .CW(CW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .rel   (release_o),
  .phase (phase_o),
  .req   (req),
  .gnt   (gnt),
  .cnt   (cnt_q)
);

// File: tb/tb_sbar_unit.sv
`timescale 1ns/1ps
module tb_sbar_unit;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [P-1:0] arrive = '0;
  logic [P-1:0] release_o;
  logic         phase_o, dup_err_o;

  sbar_unit #(.N(P)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive_i  (arrive),
    .release_o (release_o),
    .phase_o   (phase_o),
    .dup_err_o (dup_err_o)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit running = 1'b0;

  typedef struct { int at; logic [P-1:0] m; logic ph; } rel_t;
  rel_t    exp_q[$];
  bit      err_exp[int];

  // requirement-level model
  logic [P-1:0] wset = '0;
  int           cnt_m = 0;
  logic         ph_m = 1'b0;
  int           next_free = 0;
  int           clear_at = -1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cyc %0d)", req, what, act, exp, cyc);
    end
  endtask

  // driver: applies one arrival pattern for one cycle and predicts its effects
  task automatic go(input logic [P-1:0] m);
    int c;
    @(negedge clk);
    if (clear_at >= 0 && cyc >= clear_at) begin wset = '0; clear_at = -1; end
    c = cyc;
    if ((m & wset) != '0) err_exp[c+1] = 1'b1;           // R8
    if (next_free < c + 1) next_free = c + 1;
    for (int i = 0; i < P; i++) begin
      if (m[i] && !wset[i]) begin
        int e;
        wset[i] = 1'b1;
        e = next_free;
        next_free++;
        cnt_m++;
        if (cnt_m == P) begin
          cnt_m = 0;
          ph_m  = ~ph_m;
          exp_q.push_back('{e + 1 - 1, '1, ph_m});
          clear_at = e;
        end
      end
    end
    arrive = m;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      arrive = '0;
    end
  endtask

  // monitor: compares release, phase and error pulses every cycle
  always @(negedge clk) begin
    if (running) begin
      bit ee;
      ee = err_exp.exists(cyc);
      if (ee || dup_err_o) chk(dup_err_o == ee, "R8", "dup_err_o", dup_err_o, ee);
      while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
        chk(1'b0, "R3", "missed release", 0, exp_q[0].at);
        void'(exp_q.pop_front());
      end
      if (release_o != '0) begin
        if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
          chk(release_o == exp_q[0].m, "R5", "release mask", release_o, exp_q[0].m);
          chk(phase_o == exp_q[0].ph, "R4", "phase at release", phase_o, exp_q[0].ph);
          void'(exp_q.pop_front());
        end else begin
          chk(1'b0, "R6", "unexpected release", release_o, 0);
        end
      end else if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
        chk(1'b0, "R5", "release missing", release_o, exp_q[0].m);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    for (int w = 0; w < 5000; w++) @(posedge clk);
    chk(1'b0, "R3", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk(release_o == '0, "R1", "release in reset", release_o, 0);
    chk(phase_o == 1'b0, "R1", "phase in reset", phase_o, 0);
    chk(dup_err_o == 1'b0, "R1", "err in reset", dup_err_o, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    chk(release_o == '0 && phase_o == 1'b0, "R1", "state after reset", {release_o, phase_o}, 0);

    // episode 1: staggered single arrivals
    go(4'b0100); idle(2);
    go(4'b0001); idle(1);
    go(4'b1000); idle(4);
    chk(release_o == '0, "R2", "no release with three arrivals", release_o, 0);
    chk(phase_o == 1'b0, "R2", "phase held with three arrivals", phase_o, 0);
    go(4'b0010); idle(4);
    chk(phase_o == 1'b1, "R4", "phase after episode 1", phase_o, 1);

    // episode 2: all arrive together, serialized over four edges
    go(4'b1111); idle(7);
    chk(phase_o == 1'b0, "R3", "phase after simultaneous episode", phase_o, 0);

    // episode 3 then arrival inside its release cycle (R7), then duplicate (R8)
    go(4'b0011);
    go(4'b1100);
    idle(2);
    go(4'b0001);                    // lands in the release cycle: R7
    go(4'b0001);                    // waiting agent again: ignored, R8
    idle(2);
    go(4'b1110); idle(6);
    chk(phase_o == 1'b0, "R7", "phase after episode 4", phase_o, 0);

    // episode 5: duplicate from an agent still pending in the arbiter
    go(4'b1111);
    go(4'b1000);                    // R8 with requests queued
    idle(8);
    chk(phase_o == 1'b1, "R8", "phase after episode 5", phase_o, 1);
    chk(exp_q.size() == 0, "R5", "releases outstanding", exp_q.size(), 0);

    running = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule